// File: doc/BRIEF.md
# AXI Address Window Permission Guard

This block sits between AXI masters and an interconnect, on the read-address and write-address channels. Software sets up to eight address windows through a small write-only register port. Each window has an inclusive base and limit, an access mode and a mask of protection bits that a request must carry. Every incoming read or write request is looked up against these windows. A request that passes goes downstream unchanged. A request that fails is taken in and answered locally with a decode-error response, and it never reaches the interconnect.

A rejected read gets a full burst of error beats. For a rejected write, the guard takes in its data beats and then returns an error write response. Until that local response is done, the command channel that carried the failed request stays closed. Data beats and responses of accepted traffic pass straight through. The guard steers them only where they meet its own error traffic.

Top module: `axi_range_guard`

## Requirements
- R1: After reset every window is disabled (mode 0), so each read or write request is rejected. No response is pending at reset.
- R2: A request whose address lies in an enabled window, inclusive of base and limit, and which passes that window's mode and mask goes to the m_ side in the same cycle, with address, id, length and protection unchanged. R and B responses from downstream return unchanged.
- R3: Mode encoding. 0 = disabled, and the window never matches. 1 = reads only. 2 = writes only. 3 = reads and writes. A request in the wrong direction for its window is rejected.
- R4: When windows overlap, the enabled window with the lowest index decides the outcome alone.
- R5: The protection check passes only when (prot & mask) == mask. Here prot is ARPROT or AWPROT and mask is the window's 3-bit mask.
- R6: A request that matches no enabled window is rejected.
- R7: A rejected read returns ARLEN+1 beats with RRESP=2'b11, the request's RID, and RLAST only on the last beat. These beats never split a downstream R burst that is in progress. Downstream R is held off (m_rready low) while they are sent.
- R8: The W beats of a rejected write are accepted and not forwarded, up to and including WLAST. After that, BRESP=2'b11 is returned with the request's BID. W beats of writes forwarded earlier still go downstream first.
- R9: From the cycle after a request is rejected until its local response completes, that channel's s_ ready and m_ valid stay low.
- R10: The register port writes on reg_we. reg_addr = {window index, field}, where field 0 = base, 1 = limit, 2 = mode (data bits 1:0) and 3 = mask (data bits 2:0).
- R11: A local write response goes ahead of a downstream one. While it is pending, m_bready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | {window index, field} |
| reg_wdata | input | 32 | Register write data |
| s_arvalid | input | 1 | Upstream read request valid |
| s_arready | output | 1 | Upstream read request ready |
| s_araddr | input | 32 | Read address |
| s_arprot | input | 3 | Read protection |
| s_arid | input | 4 | Read id |
| s_arlen | input | 8 | Read burst length minus one |
| m_arvalid | output | 1 | Downstream read request valid |
| m_arready | input | 1 | Downstream read request ready |
| m_araddr | output | 32 | Forwarded read address |
| m_arprot | output | 3 | Forwarded read protection |
| m_arid | output | 4 | Forwarded read id |
| m_arlen | output | 8 | Forwarded read length |
| s_rvalid | output | 1 | Upstream read data valid |
| s_rready | input | 1 | Upstream read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rid | output | 4 | Read data id |
| s_rlast | output | 1 | Last read beat |
| m_rvalid | input | 1 | Downstream read data valid |
| m_rready | output | 1 | Downstream read data ready |
| m_rdata | input | 32 | Downstream read data |
| m_rresp | input | 2 | Downstream read response |
| m_rid | input | 4 | Downstream read id |
| m_rlast | input | 1 | Downstream last beat |
| s_awvalid | input | 1 | Upstream write request valid |
| s_awready | output | 1 | Upstream write request ready |
| s_awaddr | input | 32 | Write address |
| s_awprot | input | 3 | Write protection |
| s_awid | input | 4 | Write id |
| s_awlen | input | 8 | Write burst length minus one |
| m_awvalid | output | 1 | Downstream write request valid |
| m_awready | input | 1 | Downstream write request ready |
| m_awaddr | output | 32 | Forwarded write address |
| m_awprot | output | 3 | Forwarded write protection |
| m_awid | output | 4 | Forwarded write id |
| m_awlen | output | 8 | Forwarded write length |
| s_wvalid | input | 1 | Upstream write data valid |
| s_wready | output | 1 | Upstream write data ready |
| s_wdata | input | 32 | Write data |
| s_wlast | input | 1 | Last write beat |
| m_wvalid | output | 1 | Downstream write data valid |
| m_wready | input | 1 | Downstream write data ready |
| m_wdata | output | 32 | Forwarded write data |
| m_wlast | output | 1 | Forwarded last beat |
| s_bvalid | output | 1 | Upstream write response valid |
| s_bready | input | 1 | Upstream write response ready |
| s_bresp | output | 2 | Write response |
| s_bid | output | 4 | Write response id |
| m_bvalid | input | 1 | Downstream write response valid |
| m_bready | output | 1 | Downstream write response ready |
| m_bresp | input | 2 | Downstream write response |
| m_bid | input | 4 | Downstream write response id |

## Verification
A corrupted window register or a wrong priority pick shows up in the same cycle the request is presented. m_arvalid or m_awvalid then disagrees with the expected verdict, with no register in between. A wrong beat counter or captured id shows within ARLEN+1 cycles, as a missing or extra RLAST or a foreign RID on the error burst. An outstanding-write count that is off shows when the next rejected write's W beats arrive. Either W data that belongs downstream is swallowed, or a rejected burst leaks onto m_wvalid. A stuck error state shows as a command channel whose ready never comes back.

// File: rtl/arg_pkg.sv
package arg_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_RO  = 2'd1,
    MODE_WO  = 2'd2,
    MODE_RW  = 2'd3
  } mode_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_DECERR = 2'b11;
  localparam int unsigned PROT_W = 3;

  // direction check: is_wr selects write permission
  function automatic logic mode_allows(input mode_e m, input logic is_wr);
    if (is_wr) return (m == MODE_WO) || (m == MODE_RW);
    else       return (m == MODE_RO) || (m == MODE_RW);
  endfunction

  // every required bit must be present in the request protection
  function automatic logic prot_ok(input logic [PROT_W-1:0] prot,
                                   input logic [PROT_W-1:0] need);
    return (prot & need) == need;
  endfunction

endpackage

// File: rtl/arg_range_regs.sv
module arg_range_regs
  import arg_pkg::*;
#(
  parameter int unsigned NR = 8,
  parameter int unsigned AW = 32,
  localparam int unsigned IDX_W = (NR > 1) ? $clog2(NR) : 1,
  localparam int unsigned RA_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [AW-1:0]     reg_wdata,
  output logic [AW-1:0]     base_o  [NR],
  output logic [AW-1:0]     limit_o [NR],
  output mode_e             mode_o  [NR],
  output logic [PROT_W-1:0] mask_o  [NR]
);

  logic [IDX_W-1:0] sel_idx;
  logic [1:0]       sel_fld;

  assign sel_idx = reg_addr[RA_W-1:2];
  assign sel_fld = reg_addr[1:0];

  for (genvar g = 0; g < NR; g++) begin : g_win
    logic hit_me;
    assign hit_me = reg_we && (sel_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_o[g]  <= '0;
        limit_o[g] <= '0;
        mode_o[g]  <= MODE_OFF;
        mask_o[g]  <= '0;
      end else if (hit_me) begin
        case (sel_fld)
          2'd0:    base_o[g]  <= reg_wdata;
          2'd1:    limit_o[g] <= reg_wdata;
          2'd2:    mode_o[g]  <= mode_e'(reg_wdata[1:0]);
          default: mask_o[g]  <= reg_wdata[PROT_W-1:0];
        endcase
      end
    end
  end

endmodule

// File: rtl/arg_decode.sv
module arg_decode
  import arg_pkg::*;
#(
  parameter int unsigned NR = 8,
  parameter int unsigned AW = 32,
  parameter bit          IS_WR = 1'b0,
  localparam int unsigned IDX_W = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic [AW-1:0]     addr_i,
  input  logic [PROT_W-1:0] prot_i,
  input  logic [AW-1:0]     base_i  [NR],
  input  logic [AW-1:0]     limit_i [NR],
  input  mode_e             mode_i  [NR],
  input  logic [PROT_W-1:0] mask_i  [NR],
  output logic              hit_o,
  output logic              allow_o
);

  function automatic logic in_window(input logic [AW-1:0] a,
                                     input logic [AW-1:0] lo,
                                     input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  logic [IDX_W-1:0] win_idx;

  // scan high to low so the lowest matching index is left standing
  always_comb begin
    hit_o   = 1'b0;
    win_idx = '0;
    for (int i = NR - 1; i >= 0; i--) begin
      if (mode_i[i] != MODE_OFF && in_window(addr_i, base_i[i], limit_i[i])) begin
        hit_o   = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
    allow_o = hit_o && mode_allows(mode_i[win_idx], IS_WR)
              && prot_ok(prot_i, mask_i[win_idx]);
  end

endmodule

// File: rtl/arg_rd_path.sv
module arg_rd_path
  import arg_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  parameter int unsigned IDW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allow_i,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [AW-1:0]     s_araddr,
  input  logic [PROT_W-1:0] s_arprot,
  input  logic [IDW-1:0]    s_arid,
  input  logic [7:0]        s_arlen,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic [AW-1:0]     m_araddr,
  output logic [PROT_W-1:0] m_arprot,
  output logic [IDW-1:0]    m_arid,
  output logic [7:0]        m_arlen,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DW-1:0]     s_rdata,
  output logic [1:0]        s_rresp,
  output logic [IDW-1:0]    s_rid,
  output logic              s_rlast,
  input  logic              m_rvalid,
  output logic              m_rready,
  input  logic [DW-1:0]     m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic [IDW-1:0]    m_rid,
  input  logic              m_rlast,
  output logic              reject_o,
  output logic              busy_o,
  output logic              loc_o
);

  typedef enum logic {RD_PASS, RD_ERR} rd_st_e;

  rd_st_e         st_q;
  logic [7:0]     left_q;
  logic [IDW-1:0] eid_q;
  logic           dn_mid_q;

  assign m_araddr = s_araddr;
  assign m_arprot = s_arprot;
  assign m_arid   = s_arid;
  assign m_arlen  = s_arlen;

  assign busy_o   = (st_q == RD_ERR);
  assign reject_o = (st_q == RD_PASS) && s_arvalid && !allow_i;
  assign loc_o    = busy_o && !dn_mid_q;

  always_comb begin
    if (st_q == RD_PASS) begin
      m_arvalid = s_arvalid && allow_i;
      s_arready = allow_i ? m_arready : 1'b1;
    end else begin
      m_arvalid = 1'b0;
      s_arready = 1'b0;
    end
  end

  assign s_rvalid = loc_o ? 1'b1          : m_rvalid;
  assign s_rdata  = loc_o ? '0            : m_rdata;
  assign s_rresp  = loc_o ? RESP_DECERR   : m_rresp;
  assign s_rid    = loc_o ? eid_q         : m_rid;
  assign s_rlast  = loc_o ? (left_q == 8'd0) : m_rlast;
  assign m_rready = loc_o ? 1'b0          : s_rready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= RD_PASS;
      left_q   <= '0;
      eid_q    <= '0;
      dn_mid_q <= 1'b0;
    end else begin
      if (m_rvalid && m_rready) dn_mid_q <= !m_rlast;
      if (reject_o) begin
        st_q   <= RD_ERR;
        left_q <= s_arlen;
        eid_q  <= s_arid;
      end else if (loc_o && s_rready) begin
        if (left_q == 8'd0) st_q <= RD_PASS;
        else                left_q <= left_q - 8'd1;
      end
    end
  end

endmodule

// File: rtl/arg_wr_path.sv
module arg_wr_path
  import arg_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned IDW    = 4,
  parameter int unsigned PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allow_i,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [AW-1:0]     s_awaddr,
  input  logic [PROT_W-1:0] s_awprot,
  input  logic [IDW-1:0]    s_awid,
  input  logic [7:0]        s_awlen,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [AW-1:0]     m_awaddr,
  output logic [PROT_W-1:0] m_awprot,
  output logic [IDW-1:0]    m_awid,
  output logic [7:0]        m_awlen,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [DW-1:0]     s_wdata,
  input  logic              s_wlast,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [DW-1:0]     m_wdata,
  output logic              m_wlast,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  output logic [IDW-1:0]    s_bid,
  input  logic              m_bvalid,
  output logic              m_bready,
  input  logic [1:0]        m_bresp,
  input  logic [IDW-1:0]    m_bid,
  output logic              reject_o,
  output logic              busy_o,
  output logic              sink_o,
  output logic              bloc_o
);

  typedef enum logic [1:0] {WR_PASS, WR_DRAIN, WR_RESP} wr_st_e;

  wr_st_e            st_q;
  logic [IDW-1:0]    eid_q;
  logic [PEND_W-1:0] pend_q;
  logic              pend_full;
  logic              aw_fwd;
  logic              w_fwd_last;

  assign m_awaddr = s_awaddr;
  assign m_awprot = s_awprot;
  assign m_awid   = s_awid;
  assign m_awlen  = s_awlen;
  assign m_wdata  = s_wdata;
  assign m_wlast  = s_wlast;

  assign pend_full = (pend_q == '1);
  assign busy_o    = (st_q != WR_PASS);
  assign reject_o  = (st_q == WR_PASS) && s_awvalid && !allow_i;
  assign sink_o    = (st_q == WR_DRAIN) && (pend_q == '0);
  assign bloc_o    = (st_q == WR_RESP);

  always_comb begin
    if (st_q == WR_PASS) begin
      m_awvalid = s_awvalid && allow_i && !pend_full;
      s_awready = allow_i ? (m_awready && !pend_full) : 1'b1;
    end else begin
      m_awvalid = 1'b0;
      s_awready = 1'b0;
    end
  end

  assign aw_fwd     = m_awvalid && m_awready;
  assign m_wvalid   = sink_o ? 1'b0 : s_wvalid;
  assign s_wready   = sink_o ? 1'b1 : m_wready;
  assign w_fwd_last = m_wvalid && m_wready && m_wlast;

  assign s_bvalid = bloc_o || m_bvalid;
  assign s_bresp  = bloc_o ? RESP_DECERR : m_bresp;
  assign s_bid    = bloc_o ? eid_q       : m_bid;
  assign m_bready = !bloc_o && s_bready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WR_PASS;
      eid_q  <= '0;
      pend_q <= '0;
    end else begin
      if (aw_fwd && !w_fwd_last)      pend_q <= pend_q + 1'b1;
      else if (!aw_fwd && w_fwd_last) pend_q <= pend_q - 1'b1;
      case (st_q)
        WR_PASS: if (reject_o) begin
          st_q  <= WR_DRAIN;
          eid_q <= s_awid;
        end
        WR_DRAIN: if (sink_o && s_wvalid && s_wlast) st_q <= WR_RESP;
        default:  if (s_bready) st_q <= WR_PASS;
      endcase
    end
  end

endmodule

// File: rtl/axi_range_guard.sv
module axi_range_guard
  import arg_pkg::*;
#(
  parameter int unsigned NR     = 8,
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned IDW    = 4,
  parameter int unsigned PEND_W = 4,
  localparam int unsigned IDX_W = (NR > 1) ? $clog2(NR) : 1,
  localparam int unsigned RA_W  = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [AW-1:0]     reg_wdata,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [AW-1:0]     s_araddr,
  input  logic [2:0]        s_arprot,
  input  logic [IDW-1:0]    s_arid,
  input  logic [7:0]        s_arlen,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic [AW-1:0]     m_araddr,
  output logic [2:0]        m_arprot,
  output logic [IDW-1:0]    m_arid,
  output logic [7:0]        m_arlen,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DW-1:0]     s_rdata,
  output logic [1:0]        s_rresp,
  output logic [IDW-1:0]    s_rid,
  output logic              s_rlast,
  input  logic              m_rvalid,
  output logic              m_rready,
  input  logic [DW-1:0]     m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic [IDW-1:0]    m_rid,
  input  logic              m_rlast,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [AW-1:0]     s_awaddr,
  input  logic [2:0]        s_awprot,
  input  logic [IDW-1:0]    s_awid,
  input  logic [7:0]        s_awlen,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [AW-1:0]     m_awaddr,
  output logic [2:0]        m_awprot,
  output logic [IDW-1:0]    m_awid,
  output logic [7:0]        m_awlen,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [DW-1:0]     s_wdata,
  input  logic              s_wlast,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [DW-1:0]     m_wdata,
  output logic              m_wlast,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  output logic [IDW-1:0]    s_bid,
  input  logic              m_bvalid,
  output logic              m_bready,
  input  logic [1:0]        m_bresp,
  input  logic [IDW-1:0]    m_bid
);

  logic [AW-1:0]     win_base  [NR];
  logic [AW-1:0]     win_limit [NR];
  mode_e             win_mode  [NR];
  logic [PROT_W-1:0] win_mask  [NR];

  // named internal events, watched by the bound checker
  logic rd_hit, rd_allow, rd_reject, rd_busy, rd_loc;
  logic wr_hit, wr_allow, wr_reject, wr_busy, w_sink, b_loc;

  arg_range_regs #(.NR(NR), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .base_o(win_base), .limit_o(win_limit),
    .mode_o(win_mode), .mask_o(win_mask)
  );

  arg_decode #(.NR(NR), .AW(AW), .IS_WR(1'b0)) u_rd_dec (
    .addr_i(s_araddr), .prot_i(s_arprot), .base_i(win_base),
    .limit_i(win_limit), .mode_i(win_mode), .mask_i(win_mask),
    .hit_o(rd_hit), .allow_o(rd_allow)
  );

  arg_decode #(.NR(NR), .AW(AW), .IS_WR(1'b1)) u_wr_dec (
    .addr_i(s_awaddr), .prot_i(s_awprot), .base_i(win_base),
    .limit_i(win_limit), .mode_i(win_mode), .mask_i(win_mask),
    .hit_o(wr_hit), .allow_o(wr_allow)
  );

  arg_rd_path #(.AW(AW), .DW(DW), .IDW(IDW)) u_rd (
    .clk(clk), .rst_n(rst_n), .allow_i(rd_allow),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
    .s_arprot(s_arprot), .s_arid(s_arid), .s_arlen(s_arlen),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
    .m_arprot(m_arprot), .m_arid(m_arid), .m_arlen(m_arlen),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
    .s_rresp(s_rresp), .s_rid(s_rid), .s_rlast(s_rlast),
    .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata),
    .m_rresp(m_rresp), .m_rid(m_rid), .m_rlast(m_rlast),
    .reject_o(rd_reject), .busy_o(rd_busy), .loc_o(rd_loc)
  );

  arg_wr_path #(.AW(AW), .DW(DW), .IDW(IDW), .PEND_W(PEND_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .allow_i(wr_allow),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
    .s_awprot(s_awprot), .s_awid(s_awid), .s_awlen(s_awlen),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
    .m_awprot(m_awprot), .m_awid(m_awid), .m_awlen(m_awlen),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata),
    .s_wlast(s_wlast), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_wdata(m_wdata), .m_wlast(m_wlast),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_bid(s_bid), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .m_bresp(m_bresp), .m_bid(m_bid),
    .reject_o(wr_reject), .busy_o(wr_busy), .sink_o(w_sink), .bloc_o(b_loc)
  );

endmodule

// File: rtl/arg_checker.sv
module arg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       s_arvalid,
  input logic       s_arready,
  input logic       m_arvalid,
  input logic       s_awvalid,
  input logic       s_awready,
  input logic       m_awvalid,
  input logic       s_rvalid,
  input logic       s_rready,
  input logic [1:0] s_rresp,
  input logic       m_rready,
  input logic       m_wvalid,
  input logic       s_bvalid,
  input logic [1:0] s_bresp,
  input logic       m_bready,
  input logic       rd_hit,
  input logic       wr_hit,
  input logic       rd_reject,
  input logic       wr_reject,
  input logic       rd_busy,
  input logic       wr_busy,
  input logic       rd_loc,
  input logic       w_sink,
  input logic       b_loc
);

  a_r9_ar_closed: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |-> (!s_arready && !m_arvalid));

  a_r9_aw_closed: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> (!s_awready && !m_awvalid));

  a_r9_rd_enter: assert property (@(posedge clk) disable iff (!rst_n)
    rd_reject |=> rd_busy);

  a_r9_wr_enter: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> wr_busy);

  a_r6_rd_nomatch: assert property (@(posedge clk) disable iff (!rst_n)
    (s_arvalid && !rd_hit && !rd_busy) |-> (s_arready && !m_arvalid));

  a_r6_wr_nomatch: assert property (@(posedge clk) disable iff (!rst_n)
    (s_awvalid && !wr_hit && !wr_busy) |-> (s_awready && !m_awvalid));

  a_r7_local_rresp: assert property (@(posedge clk) disable iff (!rst_n)
    rd_loc |-> (s_rvalid && s_rresp == 2'b11 && !m_rready));

  a_r7_local_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_loc && !s_rready) |=> rd_loc);

  a_r8_sink_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    w_sink |-> !m_wvalid);

  a_r11_local_b_first: assert property (@(posedge clk) disable iff (!rst_n)
    b_loc |-> (s_bvalid && s_bresp == 2'b11 && !m_bready));

endmodule

bind axi_range_guard arg_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .s_arvalid(s_arvalid), .s_arready(s_arready), .m_arvalid(m_arvalid),
  .s_awvalid(s_awvalid), .s_awready(s_awready), .m_awvalid(m_awvalid),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rresp(s_rresp),
  .m_rready(m_rready), .m_wvalid(m_wvalid),
  .s_bvalid(s_bvalid), .s_bresp(s_bresp), .m_bready(m_bready),
  .rd_hit(rd_hit), .wr_hit(wr_hit),
  .rd_reject(rd_reject), .wr_reject(wr_reject),
  .rd_busy(rd_busy), .wr_busy(wr_busy),
  .rd_loc(rd_loc), .w_sink(w_sink), .b_loc(b_loc)
);

// File: tb/axi_range_guard_tb_top.sv
`timescale 1ns/1ps
module axi_range_guard_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        s_arvalid, s_arready, m_arvalid, m_arready;
  logic [31:0] s_araddr, m_araddr;
  logic [2:0]  s_arprot, m_arprot;
  logic [3:0]  s_arid, m_arid;
  logic [7:0]  s_arlen, m_arlen;
  logic        s_rvalid, s_rready, s_rlast, m_rvalid, m_rready, m_rlast;
  logic [31:0] s_rdata, m_rdata;
  logic [1:0]  s_rresp, m_rresp;
  logic [3:0]  s_rid, m_rid;
  logic        s_awvalid, s_awready, m_awvalid, m_awready;
  logic [31:0] s_awaddr, m_awaddr;
  logic [2:0]  s_awprot, m_awprot;
  logic [3:0]  s_awid, m_awid;
  logic [7:0]  s_awlen, m_awlen;
  logic        s_wvalid, s_wready, s_wlast, m_wvalid, m_wready, m_wlast;
  logic [31:0] s_wdata, m_wdata;
  logic        s_bvalid, s_bready, m_bvalid, m_bready;
  logic [1:0]  s_bresp, m_bresp;
  logic [3:0]  s_bid, m_bid;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  axi_range_guard dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=<20000", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // R10: reg_addr = {index, field}
  task automatic wreg(input int idx, input int fld, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {3'(idx), 2'(fld)}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_win(input int idx, input logic [31:0] lo, input logic [31:0] hi,
                         input int mode, input int mask);
    wreg(idx, 0, lo); wreg(idx, 1, hi); wreg(idx, 2, 32'(mode)); wreg(idx, 3, 32'(mask));
  endtask

  task automatic do_read(input string req, input logic [31:0] a, input logic [2:0] p,
                         input logic [3:0] id, input logic [7:0] len, input bit ok);
    int cnt;
    @(negedge clk);
    s_arvalid = 1'b1; s_araddr = a; s_arprot = p; s_arid = id; s_arlen = len;
    #1;
    if (ok) chk(m_arvalid && m_araddr == a && m_arid == id && m_arlen == len,
                req, "read forwarded", {31'd0, m_arvalid}, 1);
    else    chk(!m_arvalid && s_arready, req, "read taken locally", {31'd0, m_arvalid}, 0);
    @(negedge clk);
    s_arvalid = 1'b0;
    if (ok) begin
      for (int b = 0; b <= int'(len); b++) begin
        m_rvalid = 1'b1; m_rdata = 32'hA000_0000 + b; m_rid = id; m_rresp = 2'b00;
        m_rlast = (b == int'(len));
        #1;
        chk(s_rvalid && s_rdata == 32'hA000_0000 + b && s_rid == id && s_rresp == 2'b00,
            "R2", "read data passthrough", s_rdata, 32'hA000_0000 + b);
        @(negedge clk);
      end
      m_rvalid = 1'b0; m_rlast = 1'b0;
    end else begin
      cnt = 0;
      for (int k = 0; k < int'(len) + 4; k++) begin
        #1;
        if (s_rvalid) begin
          chk(s_rresp == 2'b11 && s_rid == id && s_rlast == (cnt == int'(len)),
              "R7", "error beat", {s_rresp, s_rid, s_rlast}, {2'b11, id, 1'(cnt == int'(len))});
          if (cnt == 0) chk(!s_arready, "R9", "AR closed during error", s_arready, 0);
          cnt++;
        end
        @(negedge clk);
      end
      chk(cnt == int'(len) + 1, "R7", "error beat count", cnt, int'(len) + 1);
    end
  endtask

  task automatic do_write(input string req, input logic [31:0] a, input logic [2:0] p,
                          input logic [3:0] id, input logic [7:0] len, input bit ok);
    @(negedge clk);
    s_awvalid = 1'b1; s_awaddr = a; s_awprot = p; s_awid = id; s_awlen = len;
    #1;
    if (ok) chk(m_awvalid && m_awaddr == a && m_awid == id, req, "write forwarded",
                {31'd0, m_awvalid}, 1);
    else    chk(!m_awvalid && s_awready, req, "write taken locally", {31'd0, m_awvalid}, 0);
    @(negedge clk);
    s_awvalid = 1'b0;
    for (int b = 0; b <= int'(len); b++) begin
      s_wvalid = 1'b1; s_wdata = 32'hB000_0000 + b; s_wlast = (b == int'(len));
      #1;
      if (ok) chk(m_wvalid && m_wdata == 32'hB000_0000 + b, "R2", "W forwarded",
                  {31'd0, m_wvalid}, 1);
      else begin
        chk(!m_wvalid && s_wready, "R8", "W sunk", {31'd0, m_wvalid}, 0);
        if (b == 0) chk(!s_awready, "R9", "AW closed during drain", s_awready, 0);
      end
      @(negedge clk);
    end
    s_wvalid = 1'b0; s_wlast = 1'b0;
    if (ok) begin
      m_bvalid = 1'b1; m_bid = id; m_bresp = 2'b00;
      #1;
      chk(s_bvalid && s_bid == id && s_bresp == 2'b00 && m_bready, "R2", "B passthrough",
          {s_bresp, s_bid}, {2'b00, id});
      @(negedge clk);
      m_bvalid = 1'b0;
    end else begin
      #1;
      chk(s_bvalid && s_bresp == 2'b11 && s_bid == id, "R8", "local BRESP",
          {s_bvalid, s_bresp, s_bid}, {1'b1, 2'b11, id});
      @(negedge clk);
      #1;
      chk(!s_bvalid, "R8", "single local B", s_bvalid, 0);
    end
  endtask

  // R8/R11: earlier forwarded W first, local B ahead of downstream B
  task automatic t_write_order();
    @(negedge clk);
    s_awvalid = 1'b1; s_awaddr = 32'h1000; s_awprot = 3'd0; s_awid = 4'd1; s_awlen = 8'd1;
    @(negedge clk);
    s_awaddr = 32'h9000; s_awid = 4'd2; s_awlen = 8'd0;
    #1;
    chk(s_awready && !m_awvalid, "R6", "second AW rejected", {31'd0, m_awvalid}, 0);
    @(negedge clk);
    s_awvalid = 1'b0;
    for (int b = 0; b < 2; b++) begin
      s_wvalid = 1'b1; s_wdata = 32'hC0 + b; s_wlast = (b == 1);
      #1;
      chk(m_wvalid && m_wdata == 32'hC0 + b, "R8", "earlier burst forwarded first",
          {31'd0, m_wvalid}, 1);
      @(negedge clk);
    end
    s_wdata = 32'hDD; s_wlast = 1'b1;
    #1;
    chk(!m_wvalid && s_wready, "R8", "rejected burst sunk", {31'd0, m_wvalid}, 0);
    @(negedge clk);
    s_wvalid = 1'b0; s_wlast = 1'b0;
    m_bvalid = 1'b1; m_bid = 4'd1; m_bresp = 2'b00;
    #1;
    chk(s_bvalid && s_bid == 4'd2 && s_bresp == 2'b11 && !m_bready, "R11",
        "local B first", {s_bid, s_bresp}, {4'd2, 2'b11});
    @(negedge clk);
    #1;
    chk(s_bvalid && s_bid == 4'd1 && s_bresp == 2'b00 && m_bready, "R11",
        "downstream B after", {s_bid, s_bresp}, {4'd1, 2'b00});
    @(negedge clk);
    m_bvalid = 1'b0;
  endtask

  // R7: local error beats wait for a downstream burst in progress
  task automatic t_read_mid_burst();
    @(negedge clk);
    s_arvalid = 1'b1; s_araddr = 32'h1000; s_arprot = 3'd0; s_arid = 4'd3; s_arlen = 8'd1;
    @(negedge clk);
    s_arvalid = 1'b0;
    m_rvalid = 1'b1; m_rid = 4'd3; m_rdata = 32'h11; m_rresp = 2'b00; m_rlast = 1'b0;
    @(negedge clk);
    m_rvalid = 1'b0;
    s_arvalid = 1'b1; s_araddr = 32'h9000; s_arid = 4'd4; s_arlen = 8'd0;
    #1;
    chk(s_arready && !m_arvalid, "R6", "read rejected mid burst", {31'd0, m_arvalid}, 0);
    @(negedge clk);
    s_arvalid = 1'b0;
    m_rvalid = 1'b1; m_rid = 4'd3; m_rdata = 32'h22; m_rlast = 1'b1;
    #1;
    chk(s_rvalid && s_rid == 4'd3 && s_rresp == 2'b00 && m_rready, "R7",
        "downstream burst finishes first", s_rid, 4'd3);
    @(negedge clk);
    m_rvalid = 1'b0; m_rlast = 1'b0;
    #1;
    chk(s_rvalid && s_rid == 4'd4 && s_rresp == 2'b11 && s_rlast, "R7",
        "error beat after burst", {s_rid, s_rresp}, {4'd4, 2'b11});
    @(negedge clk);
    #1;
    chk(!s_rvalid, "R7", "error burst done", s_rvalid, 0);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    s_arvalid = 0; s_araddr = 0; s_arprot = 0; s_arid = 0; s_arlen = 0;
    s_awvalid = 0; s_awaddr = 0; s_awprot = 0; s_awid = 0; s_awlen = 0;
    s_wvalid = 0; s_wdata = 0; s_wlast = 0;
    s_rready = 1; s_bready = 1; m_arready = 1; m_awready = 1; m_wready = 1;
    m_rvalid = 0; m_rdata = 0; m_rresp = 0; m_rid = 0; m_rlast = 0;
    m_bvalid = 0; m_bresp = 0; m_bid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!s_rvalid && !s_bvalid && !m_arvalid && !m_awvalid, "R1", "idle after reset",
        {s_rvalid, s_bvalid}, 0);
    do_read("R1", 32'h1000, 3'd0, 4'd5, 8'd0, 1'b0);
    do_write("R1", 32'h1000, 3'd7, 4'd6, 8'd0, 1'b0);

    set_win(0, 32'h1000, 32'h1FFF, 3, 0);
    set_win(1, 32'h2000, 32'h2FFF, 1, 1);
    set_win(2, 32'h3000, 32'h3FFF, 2, 0);
    set_win(4, 32'h4000, 32'h4FFF, 1, 0);
    set_win(5, 32'h4000, 32'h4FFF, 3, 0);
    set_win(6, 32'h5000, 32'h5FFF, 0, 0);
    set_win(7, 32'h5000, 32'h5FFF, 3, 4);

    do_read ("R2", 32'h1800, 3'd0, 4'd1, 8'd2, 1'b1);
    do_write("R2", 32'h1FFF, 3'd0, 4'd2, 8'd1, 1'b1);
    do_read ("R3", 32'h3000, 3'd0, 4'd3, 8'd0, 1'b0);
    do_write("R3", 32'h3000, 3'd0, 4'd3, 8'd0, 1'b1);
    do_write("R3", 32'h2000, 3'd1, 4'd4, 8'd2, 1'b0);
    do_read ("R3", 32'h2000, 3'd1, 4'd4, 8'd0, 1'b1);
    do_read ("R5", 32'h2000, 3'd2, 4'd5, 8'd0, 1'b0);
    do_read ("R5", 32'h5000, 3'd5, 4'd6, 8'd0, 1'b1);
    do_read ("R5", 32'h5FFF, 3'd3, 4'd7, 8'd1, 1'b0);
    do_write("R4", 32'h4000, 3'd0, 4'd8, 8'd0, 1'b0);
    do_read ("R4", 32'h4ABC, 3'd0, 4'd9, 8'd0, 1'b1);
    do_read ("R6", 32'h0FFF, 3'd7, 4'd10, 8'd0, 1'b0);
    do_read ("R6", 32'h8000, 3'd0, 4'd11, 8'd3, 1'b0);
    do_write("R6", 32'h6000, 3'd0, 4'd12, 8'd2, 1'b0);
    wreg(0, 2, 32'd0);
    do_read ("R10", 32'h1000, 3'd0, 4'd13, 8'd0, 1'b0);
    wreg(0, 2, 32'd3);
    do_read ("R10", 32'h1000, 3'd0, 4'd13, 8'd0, 1'b1);
    t_write_order();
    t_read_mid_burst();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule